// File: doc/BRIEF.md
# TDC code-density calibration engine

This block turns the raw bin codes of a tapped-delay-line time-to-digital converter into calibrated time words. Each of two delay lines has its own 512-word, 8-bit mapping table. A calibration pass fills one of these tables in three phases. First it zeroes the table. It then counts random hits per bin code until a fixed power-of-two total is reached. Last, it converts the counts into bin-centre times by a running sum.

In normal use, the raw code and a line select address the table, and the word read out is the corrected time. While one line's table is being rebuilt, lookups for that line come from the other line's table. Measurement therefore never reads a half-built table. A one-cycle done pulse marks the end of each pass.

Top module: `tdc_cal_engine`

## Requirements
- R1: After reset, `busy` and `cal_done` are low.
- R2: A `cal_req` seen while idle starts a pass on line `cal_sel`, and `busy` is high in the next cycle. The pass first writes zero to all 512 table addresses, one per clock, so no old word of that table survives the pass.
- R3: During the histogram phase, each accepted hit from the selected line adds one to the count of its bin code. Hits on the other line have no effect.
- R4: A hit whose code is 511, or whose valid bit is low, is ignored and does not advance the hit total.
- R5: The histogram phase ends after exactly 2^HIT_LOG2 accepted hits. Any hits after that are ignored.
- R6: A bin count saturates at 255 and does not wrap.
- R7: Hits to the same bin on consecutive clocks are all counted.
- R8: Let c_j be the saturated count of bin j. After a pass, table word i equals min(255, (c_0 + ... + c_(i-1) + floor(c_i/2)) >> (HIT_LOG2-8)). This holds for every i from 0 to 511.
- R9: `meas_time` shows the table word for the `meas_line` and `meas_code` presented one clock earlier.
- R10: While a pass runs, a lookup aimed at the line under calibration is answered from the other line's table.
- R11: `cal_done` is high for exactly one cycle at the end of a pass, and `busy` is low in that cycle.
- R12: A `cal_req` that arrives while a pass is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cal_req | input | 1 | Start a calibration pass (taken only when idle) |
| cal_sel | input | 1 | Line to calibrate: 0 or 1 |
| hit0_vld | input | 1 | Hit strobe from line 0 |
| hit0_code | input | AW (9) | Bin code of the line 0 hit |
| hit1_vld | input | 1 | Hit strobe from line 1 |
| hit1_code | input | AW (9) | Bin code of the line 1 hit |
| meas_line | input | 1 | Line whose table a lookup reads |
| meas_code | input | AW (9) | Raw code to correct |
| meas_time | output | DW (8) | Calibrated time, one clock after the lookup |
| busy | output | 1 | A calibration pass is in progress |
| cal_done | output | 1 | One-cycle pulse at the end of a pass |

## Verification
Two hit profiles are used. The first is a dense profile of four repeating bin widths, with strobe-low gaps and code-511 strobes mixed in; its table tells whether the running sum, the half-bin offset and the ignore rules are right. The second is sparse, with one overfilled bin and long runs of identical codes; it separates saturation from wrapping and shows whether the forwarding path loses back-to-back increments. Lookups aimed at the busy line while the second line calibrates show whether they are steered to the finished table. A second pass over the first line with the sparse profile shows whether the clear phase erased the old table.

// File: rtl/tdc_cal_pkg.sv
package tdc_cal_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CLEAR = 2'd1,
    ST_RUN   = 2'd2,
    ST_NUM   = 2'd3
  } cal_state_e;
endpackage

// File: rtl/tdc_cal_bank.sv
// One per-line mapping table: synchronous write, registered read.
module tdc_cal_bank #(
  parameter int AW = 9,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      store[waddr] <= wdata;
    end
    rdata <= store[raddr];
  end
endmodule

// File: rtl/tdc_cal_ctrl.sv
// Phase sequencer: clear sweep, hit budget, numbering sweep, done pulse.
module tdc_cal_ctrl
  import tdc_cal_pkg::*;
#(
  parameter int AW       = 9,
  parameter int HIT_LOG2 = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cal_req,
  input  logic          cal_sel,
  input  logic          hit_acc,
  input  logic          hist_pend,
  input  logic          num_last,
  output cal_state_e    state,
  output logic          cal_line,
  output logic [AW-1:0] sweep_addr,
  output logic          sweep_go,
  output logic          hits_full,
  output logic          cal_done
);
  localparam int            HW         = HIT_LOG2 + 1;
  localparam logic [HW-1:0] HIT_TOTAL  = {1'b1, {HIT_LOG2{1'b0}}};
  localparam logic [AW-1:0] ADDR_LAST  = {AW{1'b1}};

  cal_state_e    state_q, state_d;
  logic          line_q, line_d;
  logic [AW-1:0] addr_q, addr_d;
  logic          swept_q, swept_d;
  logic [HW-1:0] hits_q, hits_d;
  logic          done_q, done_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (cal_req) state_d = ST_CLEAR;
      ST_CLEAR: if (addr_q == ADDR_LAST) state_d = ST_RUN;
      ST_RUN:   if (hits_full && !hist_pend) state_d = ST_NUM;
      ST_NUM:   if (num_last) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    line_d  = line_q;
    addr_d  = addr_q;
    swept_d = swept_q;
    hits_d  = hits_q;
    if (state_q == ST_IDLE && cal_req) begin
      line_d = cal_sel;
    end
    if (state_d != state_q) begin
      addr_d  = '0;
      swept_d = 1'b0;
    end else if (state_q == ST_CLEAR) begin
      addr_d = addr_q + 1'b1;
    end else if (state_q == ST_NUM && !swept_q) begin
      addr_d = addr_q + 1'b1;
      if (addr_q == ADDR_LAST) swept_d = 1'b1;
    end
    if (state_q == ST_CLEAR) begin
      hits_d = '0;
    end else if (hit_acc) begin
      hits_d = hits_q + 1'b1;
    end
    done_d = (state_q == ST_NUM) && num_last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      line_q  <= 1'b0;
      addr_q  <= '0;
      swept_q <= 1'b0;
      hits_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      line_q  <= line_d;
      addr_q  <= addr_d;
      swept_q <= swept_d;
      hits_q  <= hits_d;
      done_q  <= done_d;
    end
  end

  assign state      = state_q;
  assign cal_line   = line_q;
  assign sweep_addr = addr_q;
  assign sweep_go   = (state_q == ST_NUM) && !swept_q;
  assign hits_full  = (hits_q == HIT_TOTAL);
  assign cal_done   = done_q;
endmodule

// File: rtl/tdc_cal_hist.sv
// Histogram read-modify-write with one-entry forwarding and saturation.
module tdc_cal_hist #(
  parameter int AW = 9,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc,
  input  logic [AW-1:0] code,
  input  logic [DW-1:0] rdata,
  output logic          pend,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [DW-1:0] wdata
);
  logic          s1_v, w_v;
  logic [AW-1:0] s1_a, w_a;
  logic [DW-1:0] w_d, base, nxt;

  always_comb begin
    base = (w_v && (w_a == s1_a)) ? w_d : rdata;
    nxt  = (&base) ? base : base + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v <= 1'b0;
      s1_a <= '0;
      w_v  <= 1'b0;
      w_a  <= '0;
      w_d  <= '0;
    end else begin
      s1_v <= acc;
      if (acc) s1_a <= code;
      w_v <= s1_v;
      if (s1_v) begin
        w_a <= s1_a;
        w_d <= nxt;
      end
    end
  end

  assign pend  = s1_v;
  assign we    = s1_v;
  assign waddr = s1_a;
  assign wdata = nxt;
endmodule

// File: rtl/tdc_cal_num.sv
// Numbering sweep: running sum plus half bin, shifted to the word width.
module tdc_cal_num #(
  parameter int AW       = 9,
  parameter int DW       = 8,
  parameter int HIT_LOG2 = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic          iss_v,
  input  logic [AW-1:0] iss_a,
  input  logic [DW-1:0] rdata,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [DW-1:0] wdata,
  output logic          last
);
  localparam int            SH        = HIT_LOG2 - DW;
  localparam int            ACW       = HIT_LOG2 + 1;
  localparam logic [AW-1:0] ADDR_LAST = {AW{1'b1}};

  logic           n1_v;
  logic [AW-1:0]  n1_a;
  logic [ACW-1:0] acc_q, mid, scaled;

  always_comb begin
    mid    = acc_q + ACW'(rdata >> 1);
    scaled = mid >> SH;
    wdata  = (|scaled[ACW-1:DW]) ? {DW{1'b1}} : scaled[DW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n1_v  <= 1'b0;
      n1_a  <= '0;
      acc_q <= '0;
    end else begin
      n1_v <= iss_v;
      if (iss_v) n1_a <= iss_a;
      if (!active) begin
        acc_q <= '0;
      end else if (n1_v) begin
        acc_q <= acc_q + ACW'(rdata);
      end
    end
  end

  assign we    = n1_v;
  assign waddr = n1_a;
  assign last  = n1_v && (n1_a == ADDR_LAST);
endmodule

// File: rtl/tdc_cal_engine.sv
module tdc_cal_engine
  import tdc_cal_pkg::*;
#(
  parameter int AW       = 9,
  parameter int DW       = 8,
  parameter int HIT_LOG2 = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cal_req,
  input  logic          cal_sel,
  input  logic          hit0_vld,
  input  logic [AW-1:0] hit0_code,
  input  logic          hit1_vld,
  input  logic [AW-1:0] hit1_code,
  input  logic          meas_line,
  input  logic [AW-1:0] meas_code,
  output logic [DW-1:0] meas_time,
  output logic          busy,
  output logic          cal_done
);
  localparam int            NLINE     = 2;
  localparam logic [AW-1:0] ADDR_LAST = {AW{1'b1}};

  cal_state_e    state;
  logic          cal_line, sweep_go, hits_full, hit_acc, h_pend, num_last;
  logic [AW-1:0] sweep_addr, sel_code, cal_raddr, cal_waddr, h_waddr, n_waddr;
  logic          sel_vld, cal_we, h_we, n_we, eff_line, eff_q;
  logic [DW-1:0] cal_wdata, h_wdata, n_wdata, cal_rdata;
  logic [DW-1:0] bank_rdata [NLINE];

  tdc_cal_ctrl #(.AW(AW), .HIT_LOG2(HIT_LOG2)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cal_req(cal_req), .cal_sel(cal_sel),
    .hit_acc(hit_acc), .hist_pend(h_pend), .num_last(num_last),
    .state(state), .cal_line(cal_line), .sweep_addr(sweep_addr),
    .sweep_go(sweep_go), .hits_full(hits_full), .cal_done(cal_done)
  );

  assign busy     = (state != ST_IDLE);
  assign sel_vld  = cal_line ? hit1_vld : hit0_vld;
  assign sel_code = cal_line ? hit1_code : hit0_code;
  assign hit_acc  = (state == ST_RUN) && !hits_full && sel_vld && (sel_code != ADDR_LAST);
  assign cal_rdata = bank_rdata[cal_line];

  tdc_cal_hist #(.AW(AW), .DW(DW)) u_hist (
    .clk(clk), .rst_n(rst_n), .acc(hit_acc), .code(sel_code), .rdata(cal_rdata),
    .pend(h_pend), .we(h_we), .waddr(h_waddr), .wdata(h_wdata)
  );

  tdc_cal_num #(.AW(AW), .DW(DW), .HIT_LOG2(HIT_LOG2)) u_num (
    .clk(clk), .rst_n(rst_n), .active(state == ST_NUM), .iss_v(sweep_go),
    .iss_a(sweep_addr), .rdata(cal_rdata), .we(n_we), .waddr(n_waddr),
    .wdata(n_wdata), .last(num_last)
  );

  always_comb begin
    cal_we    = 1'b0;
    cal_waddr = sweep_addr;
    cal_wdata = '0;
    case (state)
      ST_CLEAR: cal_we = 1'b1;
      ST_RUN: begin
        cal_we    = h_we;
        cal_waddr = h_waddr;
        cal_wdata = h_wdata;
      end
      ST_NUM: begin
        cal_we    = n_we;
        cal_waddr = n_waddr;
        cal_wdata = n_wdata;
      end
      default: cal_we = 1'b0;
    endcase
  end

  assign cal_raddr = (state == ST_NUM) ? sweep_addr : sel_code;

  for (genvar g = 0; g < NLINE; g++) begin : g_bank
    logic own;
    assign own = busy && (cal_line == 1'(g));
    tdc_cal_bank #(.AW(AW), .DW(DW)) u_bank (
      .clk(clk), .we(cal_we && own), .waddr(cal_waddr), .wdata(cal_wdata),
      .raddr(own ? cal_raddr : meas_code), .rdata(bank_rdata[g])
    );
  end

  assign eff_line = (busy && (meas_line == cal_line)) ? ~meas_line : meas_line;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eff_q <= 1'b0;
    end else begin
      eff_q <= eff_line;
    end
  end

  assign meas_time = bank_rdata[eff_q];
endmodule

// File: rtl/tdc_cal_engine_chk.sv
module tdc_cal_engine_chk
  import tdc_cal_pkg::*;
#(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cal_done,
  input logic          busy,
  input cal_state_e    state,
  input logic          cal_line,
  input logic          eff_q,
  input logic          cal_we,
  input logic [DW-1:0] cal_wdata
);
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done |=> !cal_done);

  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done |-> !busy);

  // R10
  lookup_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (eff_q != cal_line));

  // R12
  line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cal_line));

  // R2
  clear_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CLEAR) |=> (state == ST_CLEAR || state == ST_RUN));

  // R3
  hist_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && cal_we) |-> (cal_wdata != '0));
endmodule

bind tdc_cal_engine tdc_cal_engine_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cal_done(cal_done), .busy(busy), .state(state),
  .cal_line(cal_line), .eff_q(eff_q), .cal_we(cal_we), .cal_wdata(cal_wdata)
);

// File: tb/sim_tdc_cal_engine.sv
module sim_tdc_cal_engine;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 9;
  localparam int DW = 8;
  localparam int HL = 12;
  localparam int DEPTH = 512;

  logic clk, rst_n, cal_req, cal_sel;
  logic hit0_vld, hit1_vld, meas_line, busy, cal_done;
  logic [AW-1:0] hit0_code, hit1_code, meas_code;
  logic [DW-1:0] meas_time;

  tdc_cal_engine #(.AW(AW), .DW(DW), .HIT_LOG2(HL)) u0 (
    .clk(clk), .rst_n(rst_n), .cal_req(cal_req), .cal_sel(cal_sel),
    .hit0_vld(hit0_vld), .hit0_code(hit0_code), .hit1_vld(hit1_vld),
    .hit1_code(hit1_code), .meas_line(meas_line), .meas_code(meas_code),
    .meas_time(meas_time), .busy(busy), .cal_done(cal_done)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc = 0;
  int done_cnt = 0;
  bit prev_done = 1'b0;
  int tab_a [DEPTH];
  int tab_b [DEPTH];
  int q_exp [$];
  int q_stamp [$];
  string q_req [$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int prof_cnt(input int prof, input int i);
    if (i == DEPTH - 1) return 0;
    if (prof == 0) begin
      if (i == 0) return 16;
      case (i % 4)
        0: return 14;
        1: return 6;
        2: return 10;
        default: return 2;
      endcase
    end
    if (i == 5) return 300;
    if (i >= 200 && i <= 214) return 252;
    if (i == 300) return 16;
    return 0;
  endfunction

  // R8 model: saturated counts, running sum plus half bin, shifted by HL-8
  task automatic build_tab(input int prof, output int tab [DEPTH]);
    int acc = 0;
    for (int i = 0; i < DEPTH; i++) begin
      int c = prof_cnt(prof, i);
      int v;
      if (c > 255) c = 255;
      v = (acc + c / 2) >> (HL - 8);
      if (v > 255) v = 255;
      tab[i] = v;
      acc += c;
    end
  endtask

  always @(posedge clk) cyc++;

  // scoreboard monitor
  always @(negedge clk) begin
    if (q_exp.size() > 0 && q_stamp[0] < cyc) begin
      check(int'(meas_time) == q_exp[0], q_req[0], int'(meas_time), q_exp[0]);
      void'(q_exp.pop_front());
      void'(q_stamp.pop_front());
      void'(q_req.pop_front());
    end
  end

  // R11 done pulse monitor
  always @(negedge clk) begin
    if (cal_done) begin
      done_cnt++;
      check(busy == 1'b0, "R11 busy at done", int'(busy), 0);
      if (prev_done) check(1'b0, "R11 done width", 2, 1);
    end
    prev_done = cal_done;
  end

  task automatic lookup(input bit line, input int code, input int exp, input string req);
    @(negedge clk);
    meas_line = line;
    meas_code = AW'(code);
    q_exp.push_back(exp);
    q_stamp.push_back(cyc);
    q_req.push_back(req);
  endtask

  task automatic set_hit(input bit line, input bit v, input int code);
    if (line) begin
      hit1_vld = v;
      hit1_code = AW'(code);
    end else begin
      hit0_vld = v;
      hit0_code = AW'(code);
    end
  endtask

  task automatic drive_prof(input bit line, input int prof);
    int k = 0;
    for (int i = 0; i < DEPTH; i++) begin
      for (int n = 0; n < prof_cnt(prof, i); n++) begin
        @(negedge clk);
        if (k % 7 == 3) begin
          set_hit(line, 1'b1, DEPTH - 1);   // R4 code 511 ignored
          @(negedge clk);
        end
        if (k % 11 == 5) begin
          set_hit(line, 1'b0, i ^ 9);       // R4 strobe low ignored
          @(negedge clk);
        end
        set_hit(line, 1'b1, i);
        k++;
      end
    end
    for (int e = 0; e < 8; e++) begin       // R5 hits beyond budget
      @(negedge clk);
      set_hit(line, 1'b1, 0);
    end
    @(negedge clk);
    set_hit(line, 1'b0, 0);
  endtask

  task automatic start_cal(input bit line);
    @(negedge clk);
    cal_sel = line;
    cal_req = 1'b1;
    @(negedge clk);
    cal_req = 1'b0;
    check(busy == 1'b1, "R2 busy after request", int'(busy), 1);
  endtask

  task automatic wait_done(input int target);
    while (done_cnt < target) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    check(1'b0, "R1 watchdog", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    build_tab(0, tab_a);
    build_tab(1, tab_b);
    rst_n = 1'b0; cal_req = 1'b0; cal_sel = 1'b0;
    hit0_vld = 1'b0; hit0_code = '0; hit1_vld = 1'b0; hit1_code = '0;
    meas_line = 1'b0; meas_code = '0;
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R1 busy in reset", int'(busy), 0);
    check(cal_done == 1'b0, "R1 done in reset", int'(cal_done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 1'b0, "R1 busy after reset", int'(busy), 0);

    // pass 1: line 0, dense profile; line 1 strobes junk (R3)
    set_hit(1'b1, 1'b1, 3);
    start_cal(1'b0);
    repeat (520) @(negedge clk);
    check(busy == 1'b1, "R2 busy after clear", int'(busy), 1);
    @(negedge clk);
    cal_sel = 1'b1; cal_req = 1'b1;          // R12 request while busy
    @(negedge clk);
    cal_req = 1'b0; cal_sel = 1'b0;
    drive_prof(1'b0, 0);
    wait_done(1);
    set_hit(1'b1, 1'b0, 0);
    check(done_cnt == 1, "R12 one pass only", done_cnt, 1);
    for (int c = 0; c < DEPTH; c++) begin
      string r = (c == 0) ? "R5" : (c == DEPTH - 2) ? "R4" : (c % 2 == 0) ? "R8" : "R3";
      lookup(1'b0, c, tab_a[c], r);
    end
    lookup(1'b0, 0, tab_a[0], "R9");
    lookup(1'b0, 510, tab_a[510], "R9");
    lookup(1'b0, 1, tab_a[1], "R9");
    lookup(1'b0, 509, tab_a[509], "R9");
    repeat (3) @(negedge clk);

    // pass 2: line 1, sparse profile; lookups to line 1 come from line 0
    set_hit(1'b0, 1'b1, 7);
    start_cal(1'b1);
    fork
      begin
        repeat (520) @(negedge clk);
        drive_prof(1'b1, 1);
      end
      begin
        repeat (20) @(negedge clk);
        for (int c = 0; c < DEPTH; c++) lookup(1'b1, c, tab_a[c], "R10");
      end
    join
    wait_done(2);
    set_hit(1'b0, 1'b0, 0);
    for (int c = 0; c < DEPTH; c++) begin
      string r = (c == 5) ? "R6" : (c >= 200 && c <= 215) ? "R7" : "R8";
      lookup(1'b1, c, tab_b[c], r);
    end
    repeat (3) @(negedge clk);

    // pass 3: line 0 again, sparse profile; clear must erase old words
    start_cal(1'b0);
    repeat (520) @(negedge clk);
    drive_prof(1'b0, 1);
    wait_done(3);
    for (int c = 0; c < DEPTH; c++) lookup(1'b0, c, tab_b[c], "R2");
    repeat (4) @(negedge clk);
    check(done_cnt == 3, "R11 pass count", done_cnt, 3);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule